// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block sits behind the pins of a byte-wide asynchronous nonvolatile memory and decides what those pins do. A bus write happens on any clock edge where chip enable and write enable are both low and the reset/power-down pin is high. Each bus write is taken as a command byte, or as the second cycle of a two-cycle sequence. Reads return one of three sources: the byte array, a two-byte identifier, or a status byte. Which source is used depends on the last read-mode command written.

Block erase and byte program each need a setup cycle followed by a second cycle. When the sequence is accepted, a down-counter models the time the memory needs inside. During that time the ready/busy pin is low. The array changes only when the count runs out. A programming-voltage-good input and the reset pin can stop an operation before it starts or abort it while it runs. The array is a small register file. Erase sets a 16-byte block to 0xFF. Program can only clear bits.

The pins are plain control pins, not a valid/ready stream. The bus has no back-pressure: the system watches the ready/busy pin or the status byte. `dout` carries data only while `dout_en` is high and is zero otherwise. `dout_en` low stands for a high-impedance bus.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After `rst_n` is released, the block is in array-read mode with `ry_by`=1, every array byte reads 0xFF, and the status byte reads 0x80.
- R2: `dout_en` is 1 only when `ce_n`=0, `oe_n`=0, `we_n`=1 and `rp_n`=1. With `ce_n`=1 it is 0 whatever `oe_n` is.
- R3: Writing 0xFF selects array reads. Writing 0x90 selects identifier reads: address bit 0 = 0 gives `ID_MAKER` (default 0xA5) and bit 0 = 1 gives `ID_PART` (default 0x3C). Writing 0x70 selects status reads.
- R4: Writing 0x20 and then 0xD0 at address A runs an erase that lasts `ERASE_CYC` cycles. At the end, all 16 bytes whose address shares A[ADDR_W-1:4] read 0xFF and no other byte changes.
- R5: After 0x20, a second write of any value other than 0xD0 starts no erase. `ry_by` stays 1 and status bit 5 (erase error) is set.
- R6: Writing 0x40 and then data D at address A runs a program that lasts `WRITE_CYC` cycles. At the end, byte A holds its old value ANDed with D.
- R7: `ry_by` is 0 for exactly the run length of an accepted operation, starting from the edge that takes the second cycle. Status bit 7 is 0 during the run. Bus writes during a run are ignored.
- R8: Taking `ce_n` high during a run neither stops nor lengthens it, and `dout_en` stays 0 meanwhile.
- R9: If `vpp_ok`=0 when the second cycle arrives, no operation starts and `ry_by` stays 1. Status bit 3 (voltage low) is set, together with bit 5 for an erase or bit 4 for a program.
- R10: If `vpp_ok` falls during a run, `ry_by` returns to 1 on the next edge and the array is left unchanged. Bits 3 and 5 (erase) or bits 3 and 4 (program) are set.
- R11: Status bits 5, 4 and 3 stay set across other commands until 0x50 is written. 0x50 clears them and does not change the read mode.
- R12: While `rp_n`=0: `dout_en` is 0, bus writes are ignored, any run is aborted and the error bits are cleared. Once released, the block is in array-read mode and array contents are kept.
- R13: After any second cycle, accepted or rejected, the block reads status until another read-mode command is written. A setup command (0x20 or 0x40) also switches reads to status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rp_n | input | 1 | Reset / deep power-down pin, active low |
| vpp_ok | input | 1 | Programming voltage above lockout |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data, valid when dout_en is high |
| dout_en | output | 1 | Output driver enable (low = high impedance) |
| ry_by | output | 1 | 1 = ready, 0 = operation running |

## Verification
The hardest situations to reach are the ones that interrupt a run partway. The supply-good input drops, or the reset pin is pulled, after the counter has started but before it has committed. Each test first programs a known non-erased pattern into the target block. It then starts the operation, waits a fixed number of cycles well inside the run, and changes the pin at a falling edge. This proves the array stayed untouched, that the right error bits came up, and that the block returned to ready on the next edge. Bus writes issued during a run, and the standby case, are driven the same way mid-run.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;
  localparam logic [7:0] CMD_READ_STAT   = 8'h70;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_CLR_STAT    = 8'h50;

  localparam int STAT_READY = 7;
  localparam int STAT_EERR  = 5;
  localparam int STAT_WERR  = 4;
  localparam int STAT_VLOW  = 3;

  typedef enum logic [1:0] {SRC_ARRAY, SRC_IDENT, SRC_STATUS} rd_src_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ERASE_ARMED, SEQ_PROG_ARMED, SEQ_RUNNING} seq_e;
  typedef enum logic {OP_ERASE, OP_PROG} op_e;
endpackage

// File: rtl/fcu_op_timer.sv
module fcu_op_timer #(
  parameter int ERASE_CYC = 2000,
  parameter int WRITE_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  input  logic is_erase,
  output logic running,
  output logic finish
);
  localparam int LONGEST = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(WRITE_CYC - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      remain  <= '0;
    end else if (clear) begin
      running <= 1'b0;
      remain  <= '0;
    end else if (start) begin
      running <= 1'b1;
      remain  <= is_erase ? ERASE_LOAD : PROG_LOAD;
    end else if (running) begin
      if (remain == '0) running <= 1'b0;
      else              remain  <= remain - 1'b1;
    end
  end

  assign finish = running && (remain == '0);
endmodule

// File: rtl/fcu_cmd_seq.sv
module fcu_cmd_seq
  import fcu_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              vpp_ok,
  input  logic              running,
  input  logic              finish,
  output rd_src_e           rd_src,
  output logic              start,
  output logic              start_erase,
  output logic              abort,
  output logic              commit_erase,
  output logic              commit_prog,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic [7:0]        status
);
  seq_e state;
  op_e  op_kind;
  logic err_erase, err_prog, err_vlow;

  assign start_erase = (state == SEQ_ERASE_ARMED);
  assign start = wr_fire && vpp_ok &&
                 ((state == SEQ_PROG_ARMED) ||
                  ((state == SEQ_ERASE_ARMED) && (wr_data == CMD_ERASE_GO)));
  assign abort = running && !vpp_ok;

  assign commit_erase = (state == SEQ_RUNNING) && finish && vpp_ok && (op_kind == OP_ERASE);
  assign commit_prog  = (state == SEQ_RUNNING) && finish && vpp_ok && (op_kind == OP_PROG);

  always_comb begin
    status = 8'h00;
    status[STAT_READY] = !running;
    status[STAT_EERR]  = err_erase;
    status[STAT_WERR]  = err_prog;
    status[STAT_VLOW]  = err_vlow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      rd_src    <= SRC_ARRAY;
      op_kind   <= OP_PROG;
      op_addr   <= '0;
      op_data   <= 8'h00;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      err_vlow  <= 1'b0;
    end else if (!rp_n) begin
      state     <= SEQ_IDLE;
      rd_src    <= SRC_ARRAY;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      err_vlow  <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (wr_fire) begin
            case (wr_data)
              CMD_READ_ARRAY: rd_src <= SRC_ARRAY;
              CMD_READ_ID:    rd_src <= SRC_IDENT;
              CMD_READ_STAT:  rd_src <= SRC_STATUS;
              CMD_CLR_STAT: begin
                err_erase <= 1'b0;
                err_prog  <= 1'b0;
                err_vlow  <= 1'b0;
              end
              CMD_ERASE_SETUP: begin
                state  <= SEQ_ERASE_ARMED;
                rd_src <= SRC_STATUS;
              end
              CMD_PROG_SETUP: begin
                state  <= SEQ_PROG_ARMED;
                rd_src <= SRC_STATUS;
              end
              default: ;
            endcase
          end
        end
        SEQ_ERASE_ARMED: begin
          if (wr_fire) begin
            rd_src <= SRC_STATUS;
            if (wr_data != CMD_ERASE_GO) begin
              err_erase <= 1'b1;
              state     <= SEQ_IDLE;
            end else if (!vpp_ok) begin
              err_erase <= 1'b1;
              err_vlow  <= 1'b1;
              state     <= SEQ_IDLE;
            end else begin
              op_kind <= OP_ERASE;
              op_addr <= wr_addr;
              state   <= SEQ_RUNNING;
            end
          end
        end
        SEQ_PROG_ARMED: begin
          if (wr_fire) begin
            rd_src <= SRC_STATUS;
            if (!vpp_ok) begin
              err_prog <= 1'b1;
              err_vlow <= 1'b1;
              state    <= SEQ_IDLE;
            end else begin
              op_kind <= OP_PROG;
              op_addr <= wr_addr;
              op_data <= wr_data;
              state   <= SEQ_RUNNING;
            end
          end
        end
        SEQ_RUNNING: begin
          if (abort) begin
            err_vlow <= 1'b1;
            if (op_kind == OP_ERASE) err_erase <= 1'b1;
            else                     err_prog  <= 1'b1;
            state <= SEQ_IDLE;
          end else if (finish) begin
            state <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcu_byte_store.sv
module fcu_byte_store #(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_en,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int NUM_BYTES = 1 << ADDR_W;

  logic [7:0] cells [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_cell
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(g);
    logic in_block, is_target;
    assign in_block  = (op_addr[ADDR_W-1:BLK_W] == SLOT[ADDR_W-1:BLK_W]);
    assign is_target = (op_addr == SLOT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cells[g] <= 8'hFF;
      else if (erase_en && in_block)   cells[g] <= 8'hFF;
      else if (prog_en && is_target)   cells[g] <= cells[g] & op_data;
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/fcu_read_mux.sv
module fcu_read_mux
  import fcu_pkg::*;
#(
  parameter logic [7:0] ID_MAKER = 8'hA5,
  parameter logic [7:0] ID_PART  = 8'h3C
) (
  input  rd_src_e    rd_src,
  input  logic       id_sel,
  input  logic [7:0] array_data,
  input  logic [7:0] status,
  output logic [7:0] rd_byte
);
  always_comb begin
    case (rd_src)
      SRC_IDENT:  rd_byte = id_sel ? ID_PART : ID_MAKER;
      SRC_STATUS: rd_byte = status;
      default:    rd_byte = array_data;
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcu_pkg::*;
#(
  parameter int         ADDR_W    = 6,
  parameter int         BLK_W     = 4,
  parameter int         ERASE_CYC = 2000,
  parameter int         WRITE_CYC = 50,
  parameter logic [7:0] ID_MAKER  = 8'hA5,
  parameter logic [7:0] ID_PART   = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              rp_n,
  input  logic              vpp_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              ry_by
);
  logic              wr_fire;
  logic              start, start_erase, abort, running, finish;
  logic              commit_erase, commit_prog;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data, status, array_data, rd_byte;
  rd_src_e           rd_src;

  assign wr_fire = !ce_n && !we_n && rp_n;

  fcu_cmd_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wr_fire(wr_fire),
    .wr_addr(addr), .wr_data(din), .vpp_ok(vpp_ok),
    .running(running), .finish(finish), .rd_src(rd_src),
    .start(start), .start_erase(start_erase), .abort(abort),
    .commit_erase(commit_erase), .commit_prog(commit_prog),
    .op_addr(op_addr), .op_data(op_data), .status(status)
  );

  fcu_op_timer #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .clear(abort || !rp_n),
    .start(start), .is_erase(start_erase),
    .running(running), .finish(finish)
  );

  fcu_byte_store #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) store_i (
    .clk(clk), .rst_n(rst_n), .erase_en(commit_erase), .prog_en(commit_prog),
    .op_addr(op_addr), .op_data(op_data), .rd_addr(addr), .rd_data(array_data)
  );

  fcu_read_mux #(.ID_MAKER(ID_MAKER), .ID_PART(ID_PART)) mux_i (
    .rd_src(rd_src), .id_sel(addr[0]), .array_data(array_data),
    .status(status), .rd_byte(rd_byte)
  );

  assign dout_en = !ce_n && !oe_n && we_n && rp_n;
  assign dout    = dout_en ? rd_byte : 8'h00;
  assign ry_by   = !running;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic rp_n,
  input logic vpp_ok,
  input logic dout_en,
  input logic ry_by
);
  // R7: a run begins only on the edge that takes a bus write
  assert_start_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ry_by) |-> $past(!ce_n && !we_n && rp_n));

  // R9: no run begins while the supply is below lockout
  assert_start_needs_vpp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ry_by) |-> $past(vpp_ok));

  // R10: a supply drop during a run ends it on the next edge
  assert_vpp_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ry_by && !vpp_ok) |=> ry_by);

  // R12: the reset pin ends any run and silences the bus
  assert_rp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> ry_by);
  assert_rp_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |-> !dout_en);

  // R2: standby or output-disable keep the bus released
  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !dout_en);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .rp_n(rp_n), .vpp_ok(vpp_ok), .dout_en(dout_en), .ry_by(ry_by)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
  localparam int ADDR_W = 6;
  localparam int NBYTES = 1 << ADDR_W;
  localparam int E_CYC  = 24;
  localparam int W_CYC  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1, vpp_ok = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic dout_en, ry_by;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model [NBYTES];

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(4), .ERASE_CYC(E_CYC), .WRITE_CYC(W_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
    .vpp_ok(vpp_ok), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .ry_by(ry_by)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_rd(logic [ADDR_W-1:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1;
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_array(logic [ADDR_W-1:0] a, output logic [7:0] d);
    logic en;
    bus_wr(0, 8'hFF);
    bus_rd(a, d, en);
  endtask

  task automatic rd_status(output logic [7:0] d);
    logic en;
    bus_wr(0, 8'h70);
    bus_rd(0, d, en);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ry_by && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic prog(logic [ADDR_W-1:0] a, logic [7:0] d);
    int n;
    bus_wr(0, 8'h40);
    bus_wr(a, d);
    wait_ready(n);
    model[a] = model[a] & d;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 ready after reset", int'(ry_by), 1);
    rd_array(0, d);   chk("R1 byte 0 erased", d, 8'hFF);
    rd_array(63, d);  chk("R1 byte 63 erased", d, 8'hFF);
    rd_status(d);     chk("R1 status", d, 8'h80);
  endtask

  task automatic t_oe_gate;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #1;
    chk("R2 ce high", int'(dout_en), 0);
    ce_n = 1'b0; oe_n = 1'b1; #1;
    chk("R2 oe high", int'(dout_en), 0);
    ce_n = 1'b1;
    @(negedge clk); din = 8'hFF; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; #1;
    chk("R2 we low", int'(dout_en), 0);
    we_n = 1'b1; #1;
    chk("R2 all active", int'(dout_en), 1);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_read_modes;
    logic [7:0] d; logic en;
    bus_wr(0, 8'h90);
    bus_rd(0, d, en); chk("R3 maker id", d, 8'hA5);
    bus_rd(1, d, en); chk("R3 part id", d, 8'h3C);
    bus_wr(0, 8'h70);
    bus_rd(5, d, en); chk("R3 status mode", d, 8'h80);
    bus_wr(0, 8'hFF);
    bus_rd(5, d, en); chk("R3 array mode", d, 8'hFF);
  endtask

  task automatic t_prog;
    logic [7:0] d; int n;
    bus_wr(0, 8'h40);
    bus_wr(5, 8'h3C);
    wait_ready(n);
    model[5] = model[5] & 8'h3C;
    chk("R7 program run length", n, W_CYC);
    rd_array(5, d); chk("R6 first program", d, 8'h3C);
    prog(5, 8'hF0);
    rd_array(5, d); chk("R6 program only clears bits", d, 8'h30);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] d; logic en; int n;
    bus_wr(0, 8'h40);
    bus_wr(10, 8'h0F);
    bus_wr(0, 8'hFF);
    bus_rd(0, d, en); chk("R7 status busy", d, 8'h00);
    wait_ready(n);
    bus_rd(0, d, en); chk("R7 write during run ignored", d, 8'h80);
    model[10] = 8'h0F;
    rd_array(10, d); chk("R7 program landed", d, 8'h0F);
  endtask

  task automatic t_standby;
    logic [7:0] d; int n;
    bus_wr(0, 8'h40);
    bus_wr(11, 8'hA5);
    oe_n = 1'b0; #1;
    chk("R8 running", int'(ry_by), 0);
    chk("R8 deselected bus off", int'(dout_en), 0);
    wait_ready(n);
    oe_n = 1'b1;
    chk("R8 run length unchanged", n, W_CYC);
    model[11] = 8'hA5;
    rd_array(11, d); chk("R8 program done in standby", d, 8'hA5);
  endtask

  task automatic t_erase;
    logic [7:0] d; logic en; int n;
    prog(17, 8'h12); prog(31, 8'h00); prog(32, 8'h55); prog(15, 8'h0F);
    bus_wr(0, 8'h20);
    bus_wr(20, 8'hD0);
    wait_ready(n);
    chk("R4 erase run length", n, E_CYC);
    bus_rd(0, d, en); chk("R13 status after erase", d, 8'h80);
    for (int i = 16; i < 32; i++) model[i] = 8'hFF;
    rd_array(15, d); chk("R4 byte below block", d, model[15]);
    rd_array(16, d); chk("R4 block first", d, 8'hFF);
    rd_array(17, d); chk("R4 block middle", d, 8'hFF);
    rd_array(31, d); chk("R4 block last", d, 8'hFF);
    rd_array(32, d); chk("R4 byte above block", d, 8'h55);
  endtask

  task automatic t_bad_confirm;
    logic [7:0] d; logic en;
    prog(18, 8'h77);
    bus_wr(0, 8'h20);
    bus_wr(16, 8'hFF);
    chk("R5 no run", int'(ry_by), 1);
    bus_rd(0, d, en); chk("R5 erase error flag", d, 8'hA0);
    rd_array(18, d); chk("R5 block untouched", d, 8'h77);
    bus_wr(0, 8'h50);
  endtask

  task automatic t_vpp_lock;
    logic [7:0] d; logic en;
    vpp_ok = 1'b0;
    bus_wr(0, 8'h40);
    bus_wr(7, 8'h00);
    chk("R9 no program start", int'(ry_by), 1);
    bus_rd(0, d, en); chk("R9 program lockout flags", d, 8'h98);
    bus_wr(0, 8'hFF);
    rd_status(d); chk("R11 flags sticky", d, 8'h98);
    bus_wr(0, 8'h50);
    bus_rd(0, d, en); chk("R11 clear keeps status mode", d, 8'h80);
    bus_wr(0, 8'h20);
    bus_wr(16, 8'hD0);
    chk("R9 no erase start", int'(ry_by), 1);
    bus_rd(0, d, en); chk("R9 erase lockout flags", d, 8'hA8);
    bus_wr(0, 8'h50);
    vpp_ok = 1'b1;
    rd_array(7, d); chk("R9 byte untouched", d, 8'hFF);
  endtask

  task automatic t_vpp_abort;
    logic [7:0] d;
    prog(17, 8'h11);
    bus_wr(0, 8'h20);
    bus_wr(17, 8'hD0);
    repeat (3) @(negedge clk);
    chk("R10 run in progress", int'(ry_by), 0);
    vpp_ok = 1'b0;
    @(negedge clk);
    chk("R10 abort to ready", int'(ry_by), 1);
    vpp_ok = 1'b1;
    rd_status(d); chk("R10 abort flags", d, 8'hA8);
    rd_array(17, d); chk("R10 array unchanged", d, 8'h11);
    bus_wr(0, 8'h50);
  endtask

  task automatic t_rp_pin;
    logic [7:0] d; logic en;
    bus_wr(0, 8'h20);
    bus_wr(0, 8'h00);
    bus_wr(0, 8'h40);
    bus_wr(40, 8'h00);
    @(negedge clk);
    rp_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; #1;
    chk("R12 bus off in reset", int'(dout_en), 0);
    oe_n = 1'b1;
    @(negedge clk);
    addr = 0; din = 8'h70; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    chk("R12 run aborted", int'(ry_by), 1);
    rp_n = 1'b1;
    bus_rd(40, d, en);
    chk("R12 array mode after release", d, 8'hFF);
    chk("R12 bus on after release", int'(en), 1);
    rd_array(17, d); chk("R12 contents kept", d, 8'h11);
    rd_status(d); chk("R12 flags cleared", d, 8'h80);
  endtask

  initial begin
    for (int i = 0; i < NBYTES; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oe_gate();
    t_read_modes();
    t_prog();
    t_busy_ignore();
    t_standby();
    t_erase();
    t_bad_confirm();
    t_vpp_lock();
    t_vpp_abort();
    t_rp_pin();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule